// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block sits between a 32-bit processor datapath and a byte-addressable data memory that is one word wide. On the store side it takes an access size, the low bits of the byte address and the register value. It returns one write enable per byte lane, plus a write-data word in which the value is repeated across the lanes. The memory then keeps only the lanes whose enables are set.

On the load side it takes the raw memory word, the same size and address bits, and a signed/unsigned flag. It returns the addressed byte, halfword or word, zero- or sign-extended to the full width. The load side is purely combinational.

A static endianness input chooses how byte addresses map onto lanes. A misalignment flag marks accesses that break the size's alignment rule, and such accesses never write memory.

Top module: `lsa_lane_aligner`

## Requirements
- R1: An unsigned byte load (size code 2'b00, signed flag 0) returns the addressed byte in bits 7..0 and zeros above it; a byte of 0xF0 yields 0x000000F0.
- R2: A signed byte load (size code 2'b00, signed flag 1) copies bit 7 of the addressed byte into every bit above it; a byte of 0xF0 yields 0xFFFFFFF0.
- R3: A halfword load (size code 2'b01) assembles the two bytes at offsets a and a+1. With the signed flag set it extends from bit 15; with the flag clear it fills with zeros. In big-endian mode the byte at offset a is the upper byte of the halfword, and in little-endian mode it is the lower byte.
- R4: With the endian input at 1 (big), byte offset o sits in bits 31-8o..24-8o. With the input at 0 (little), it sits in bits 8o+7..8o. A word load (size code 2'b10) returns the memory word unchanged.
- R5: The misalignment output is 1 for a word access at a nonzero offset, for a halfword access at an odd offset, and for the unused size code 2'b11. It is never 1 for a byte access.
- R6: While the misalignment output is 1, every byte write enable is 0.
- R7: The store write data carries the low byte on all four lanes for a byte store and the low halfword on both halves for a halfword store. For a word store it carries the value unchanged. In none of these cases does it depend on the endian input.
- R8: An aligned store raises exactly the enables of the lanes it covers, as mapped by R4. That is one lane for a byte, two lanes for a halfword and all four for a word.
- R9: Storing bytes 0x11, 0x22, 0x33, 0x44 at offsets 0 to 3 and then loading the word returns 0x11223344 in big-endian mode and 0x44332211 in little-endian mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_big_endian | input | 1 | 1 selects big-endian lane numbering, 0 little-endian |
| i_size | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 unused |
| i_addr_lo | input | 2 | Low byte-address bits of the access |
| i_store_data | input | 32 | Register value to be stored |
| o_byte_wen | output | 4 | Per-lane write enables, bit n drives bits 8n+7..8n |
| o_wr_data | output | 32 | Store data replicated onto the lanes |
| i_mem_rdata | input | 32 | Raw word read from memory |
| i_load_signed | input | 1 | 1 sign-extends a sub-word load, 0 zero-extends |
| o_load_data | output | 32 | Extracted and extended load result |
| o_misaligned | output | 1 | Access breaks the alignment rule of its size |

## Verification
The bench builds the block with its default 32-bit data width, which gives four lanes and a two-bit offset. With that width the input space is small enough to sweep completely. Every combination of endianness, all four size codes, all four offsets and both sign modes is applied against several memory words. The words are chosen so that each lane in turn has its top bit set and clear, so a sign error or a swapped lane always changes the result. A final store-then-load sequence per endian mode merges the enabled lanes into a bench-side memory word to check the end-to-end byte order.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  // Access size codes shared by the whole load/store path.
  typedef enum logic [1:0] {
    ACC_BYTE = 2'b00,
    ACC_HALF = 2'b01,
    ACC_WORD = 2'b10,
    ACC_RSVD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/lsa_align_check.sv
module lsa_align_check
  import lsa_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  acc_size_e        i_size,
  input  logic [OFS_W-1:0] i_ofs,
  output logic             o_fault
);
  // Byte accesses are always legal, halves need an even offset,
  // full words need a zero offset, the spare code is always illegal.
  always_comb begin
    unique case (i_size)
      ACC_BYTE: o_fault = 1'b0;
      ACC_HALF: o_fault = i_ofs[0];
      ACC_WORD: o_fault = |i_ofs;
      default:  o_fault = 1'b1;
    endcase
  end
endmodule

// File: rtl/lsa_store_lanes.sv
module lsa_store_lanes
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NLANE  = DATA_W / 8,
  parameter int OFS_W  = $clog2(NLANE)
) (
  input  acc_size_e         i_size,
  input  logic [OFS_W-1:0]  i_ofs,
  input  logic              i_big,
  input  logic              i_fault,
  input  logic [DATA_W-1:0] i_data,
  output logic [NLANE-1:0]  o_wen,
  output logic [DATA_W-1:0] o_wdata
);
  localparam logic [OFS_W-1:0] LAST = OFS_W'(NLANE - 1);

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam logic [OFS_W-1:0] LANE_IDX = OFS_W'(g);
    localparam int               HALF_B   = g % 2;

    logic [OFS_W-1:0] lane_addr;
    logic             lane_hit;
    logic [7:0]       lane_byte;

    // Byte address held by this lane under the selected numbering.
    assign lane_addr = i_big ? (LAST - LANE_IDX) : LANE_IDX;

    always_comb begin
      unique case (i_size)
        ACC_BYTE: lane_hit = (lane_addr == i_ofs);
        ACC_HALF: lane_hit = (lane_addr[OFS_W-1:1] == i_ofs[OFS_W-1:1]);
        ACC_WORD: lane_hit = 1'b1;
        default:  lane_hit = 1'b0;
      endcase
    end

    // Replication is endian-neutral: enables alone pick the lanes.
    always_comb begin
      unique case (i_size)
        ACC_BYTE: lane_byte = i_data[7:0];
        ACC_HALF: lane_byte = i_data[8*HALF_B +: 8];
        default:  lane_byte = i_data[8*g +: 8];
      endcase
    end

    assign o_wen[g]          = lane_hit & ~i_fault;
    assign o_wdata[8*g +: 8] = lane_byte;
  end

  // R8: an accepted access enables exactly as many lanes as its size.
  always_comb begin
    if (!i_fault) begin
      p_lane_count_r8: assert ($countones(o_wen) ==
                               ((i_size == ACC_BYTE) ? 1 :
                                (i_size == ACC_HALF) ? 2 : NLANE))
        else $error("lane count mismatch");
    end
  end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NLANE  = DATA_W / 8,
  parameter int OFS_W  = $clog2(NLANE)
) (
  input  acc_size_e         i_size,
  input  logic [OFS_W-1:0]  i_ofs,
  input  logic              i_big,
  input  logic              i_signed,
  input  logic [DATA_W-1:0] i_rdata,
  output logic [DATA_W-1:0] o_result
);
  localparam int               HW    = OFS_W - 1;
  localparam logic [OFS_W-1:0] LAST  = OFS_W'(NLANE - 1);
  localparam logic [HW-1:0]    HLAST = HW'(NLANE / 2 - 1);

  logic [OFS_W-1:0] byte_slot;
  logic [HW-1:0]    half_slot;
  logic [7:0]       byte_sel;
  logic [15:0]      half_sel;

  // Mirror the slot index in big-endian mode; halves are whole
  // 16-bit slots, so the pair order inside one matches both modes.
  always_comb begin
    byte_slot = i_big ? (LAST - i_ofs) : i_ofs;
    half_slot = i_big ? (HLAST - i_ofs[OFS_W-1:1]) : i_ofs[OFS_W-1:1];
    byte_sel  = i_rdata[{byte_slot, 3'b000} +: 8];
    half_sel  = i_rdata[{half_slot, 4'b0000} +: 16];
  end

  always_comb begin
    unique case (i_size)
      ACC_BYTE: o_result = {{(DATA_W-8){i_signed & byte_sel[7]}}, byte_sel};
      ACC_HALF: o_result = {{(DATA_W-16){i_signed & half_sel[15]}}, half_sel};
      default:  o_result = i_rdata;
    endcase
  end

  // R1: unsigned byte loads leave every upper bit clear.
  always_comb begin
    if (i_size == ACC_BYTE && !i_signed) begin
      p_zero_fill_r1: assert (o_result[DATA_W-1:8] == '0)
        else $error("upper bits not cleared");
    end
  end

  // R2: signed byte loads copy the byte's top bit upward.
  always_comb begin
    if (i_size == ACC_BYTE && i_signed) begin
      p_sign_fill_r2: assert (o_result[DATA_W-1:8] == {(DATA_W-8){o_result[7]}})
        else $error("sign not extended");
    end
  end
endmodule

// File: rtl/lsa_lane_aligner.sv
module lsa_lane_aligner
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NLANE = DATA_W / 8,
  localparam int OFS_W = $clog2(NLANE)
) (
  input  logic              i_big_endian,
  input  logic [1:0]        i_size,
  input  logic [OFS_W-1:0]  i_addr_lo,
  input  logic [DATA_W-1:0] i_store_data,
  output logic [NLANE-1:0]  o_byte_wen,
  output logic [DATA_W-1:0] o_wr_data,
  input  logic [DATA_W-1:0] i_mem_rdata,
  input  logic              i_load_signed,
  output logic [DATA_W-1:0] o_load_data,
  output logic              o_misaligned
);
  acc_size_e size;
  logic      fault;

  assign size = acc_size_e'(i_size);

  lsa_align_check #(
    .OFS_W (OFS_W)
  ) u_check (
    .i_size  (size),
    .i_ofs   (i_addr_lo),
    .o_fault (fault)
  );

  lsa_store_lanes #(
    .DATA_W (DATA_W),
    .NLANE  (NLANE),
    .OFS_W  (OFS_W)
  ) u_store (
    .i_size  (size),
    .i_ofs   (i_addr_lo),
    .i_big   (i_big_endian),
    .i_fault (fault),
    .i_data  (i_store_data),
    .o_wen   (o_byte_wen),
    .o_wdata (o_wr_data)
  );

  lsa_load_extract #(
    .DATA_W (DATA_W),
    .NLANE  (NLANE),
    .OFS_W  (OFS_W)
  ) u_load (
    .i_size   (size),
    .i_ofs    (i_addr_lo),
    .i_big    (i_big_endian),
    .i_signed (i_load_signed),
    .i_rdata  (i_mem_rdata),
    .o_result (o_load_data)
  );

  assign o_misaligned = fault;

  // R6: a faulting access never reaches memory.
  always_comb begin
    if (o_misaligned) begin
      p_no_write_on_fault_r6: assert (o_byte_wen == '0)
        else $error("write enable during fault");
    end
  end

  // R5: byte accesses are accepted at every offset.
  always_comb begin
    if (i_size == 2'b00) begin
      p_byte_never_faults_r5: assert (!o_misaligned && $countones(o_byte_wen) == 1)
        else $error("byte access rejected");
    end
  end

  // R8: an accepted word store covers every lane.
  always_comb begin
    if (i_size == 2'b10 && !o_misaligned) begin
      p_word_all_lanes_r8: assert (o_byte_wen == '1)
        else $error("word store missing lanes");
    end
  end
endmodule

// File: tb/test_lsa_lane_aligner.sv
module test_lsa_lane_aligner;
  logic        clk;
  logic        big;
  logic [1:0]  size;
  logic [1:0]  ofs;
  logic [31:0] sdata;
  logic [3:0]  wen;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        sgn;
  logic [31:0] ldata;
  logic        mis;

  int  n_chk;
  int  n_bad;
  bit  done;

  lsa_lane_aligner i_lsa_lane_aligner (
    .i_big_endian  (big),
    .i_size        (size),
    .i_addr_lo     (ofs),
    .i_store_data  (sdata),
    .o_byte_wen    (wen),
    .o_wr_data     (wdata),
    .i_mem_rdata   (rdata),
    .i_load_signed (sgn),
    .o_load_data   (ldata),
    .o_misaligned  (mis)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int lane_of(input int a, input bit b);
    return b ? 3 - a : a;
  endfunction

  function automatic logic [7:0] byte_at(input logic [31:0] w, input int a, input bit b);
    return w[8*lane_of(a, b) +: 8];
  endfunction

  task automatic apply(input bit b, input int sz, input int o, input bit s,
                       input logic [31:0] sd, input logic [31:0] rd);
    @(posedge clk);
    big = b; size = 2'(sz); ofs = 2'(o); sgn = s; sdata = sd; rdata = rd;
    @(negedge clk);
  endtask

  task automatic sweep_one(input bit b, input int sz, input int o, input bit s,
                           input logic [31:0] pat);
    logic [31:0] rd;
    bit          e_mis;
    int          nb;
    logic [3:0]  e_wen;
    logic [7:0]  bv;
    logic [15:0] hv;
    rd = {pat[15:0], pat[31:16]} ^ 32'h0F0F_F0F0;
    apply(b, sz, o, s, pat, rd);
    e_mis = (sz == 3) || (sz == 2 && o != 0) || (sz == 1 && (o % 2) == 1);
    chk("R5", "misaligned", {31'd0, mis}, {31'd0, e_mis});
    nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    e_wen = 4'b0000;
    if (!e_mis) for (int a = o; a < o + nb; a++) e_wen[lane_of(a, b)] = 1'b1;
    if (e_mis) chk("R6", "enables on fault", {28'd0, wen}, {28'd0, e_wen});
    else       chk("R8", "enables", {28'd0, wen}, {28'd0, e_wen});
    if (sz == 0) chk("R7", "byte store data", wdata, {4{pat[7:0]}});
    if (sz == 1) chk("R7", "half store data", wdata, {2{pat[15:0]}});
    if (sz == 2) chk("R7", "word store data", wdata, pat);
    if (!e_mis) begin
      if (sz == 0) begin
        bv = byte_at(rd, o, b);
        if (s) chk("R2", "signed byte load", ldata, {{24{bv[7]}}, bv});
        else   chk("R1", "unsigned byte load", ldata, {24'd0, bv});
      end else if (sz == 1) begin
        hv = b ? {byte_at(rd, o, b), byte_at(rd, o + 1, b)}
               : {byte_at(rd, o + 1, b), byte_at(rd, o, b)};
        chk("R3", "half load", ldata, s ? {{16{hv[15]}}, hv} : {16'd0, hv});
      end else begin
        chk("R4", "word load", ldata, rd);
      end
    end
  endtask

  task automatic endian_demo(input bit b);
    logic [31:0] memw;
    memw = 32'd0;
    for (int o = 0; o < 4; o++) begin
      apply(b, 0, o, 1'b0, 32'(8'h11 * (o + 1)), 32'd0);
      for (int l = 0; l < 4; l++)
        if (wen[l]) memw[8*l +: 8] = wdata[8*l +: 8];
    end
    apply(b, 2, 0, 1'b0, 32'd0, memw);
    chk("R9", b ? "big-endian word" : "little-endian word", ldata,
        b ? 32'h1122_3344 : 32'h4433_2211);
  endtask

  initial begin
    logic [31:0] pats [6];
    n_chk = 0; n_bad = 0; done = 1'b0;
    big = 1'b0; size = 2'b00; ofs = 2'b00; sgn = 1'b0;
    sdata = 32'd0; rdata = 32'd0;
    pats[0] = 32'h80F0_7F01;
    pats[1] = 32'h1234_5678;
    pats[2] = 32'hFFFF_0000;
    pats[3] = 32'h00FF_807F;
    pats[4] = 32'h7FFF_8000;
    pats[5] = 32'hA55A_C33C;
    @(negedge clk);
    // Initial state: zero inputs are an aligned little-endian byte access.
    chk("R5", "initial misaligned", {31'd0, mis}, 32'd0);
    chk("R8", "initial enables", {28'd0, wen}, 32'd1);
    chk("R1", "initial load", ldata, 32'd0);
    // Named corner values from R1 and R2.
    apply(1'b1, 0, 0, 1'b0, 32'd0, 32'hF000_0000);
    chk("R1", "0xF0 unsigned", ldata, 32'h0000_00F0);
    apply(1'b1, 0, 0, 1'b1, 32'd0, 32'hF000_0000);
    chk("R2", "0xF0 signed", ldata, 32'hFFFF_FFF0);
    for (int p = 0; p < 6; p++)
      for (int b = 0; b < 2; b++)
        for (int sz = 0; sz < 4; sz++)
          for (int o = 0; o < 4; o++)
            for (int s = 0; s < 2; s++)
              sweep_one(b[0], sz, o, s[0], pats[p]);
    endian_demo(1'b1);
    endian_demo(1'b0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule